// File: doc/BRIEF.md
# Pixel Dual Time Counter Cell

This block is the digital logic of a single detector pixel. It watches a discriminator output during a global shutter window and keeps two small counters running at once. In arrival mode, counter A measures time of arrival and counter B measures time over threshold. The width value lets downstream logic correct the timewalk of the arrival value. In counting mode, counter A counts discriminator pulses instead, while counter B still sums time over threshold. The counting mode is used to equalize pixel thresholds.

The counters are cleared when the shutter opens and are held once it closes. A hit flag tells a zero-suppressing readout whether the pixel saw anything. Four cells can be linked into a 2x2 group to get a deeper counter. A low segment is set to wrap and emits carry pulses. Each higher segment is set to follow carries and ignores its own discriminator for counting. The top segment saturates.

Top module: `pix_dual_counter`

## Requirements
- R1: After reset, both counters read 0 and the hit flag reads 0.
- R2: In the clock cycle in which `shutter` is first sampled high, both counters and the hit flag are cleared. That cycle counts no events. Counting starts in the following cycle.
- R3: With `mode`=0 and `upper`=0, counter A counts every open-shutter cycle from the first rising discriminator edge (disc high after a cycle low) through the last open cycle. Later edges in the same window do not restart it.
- R4: With `upper`=0, counter B counts every open-shutter cycle in which `disc` is high, summed over all pulses. This holds in both modes.
- R5: With `mode`=1 and `upper`=0, counter A counts rising discriminator edges seen while the shutter is open.
- R6: With `wrap_en`=0, a counter that reaches all ones (15 at the default width of 4) stays there until the next shutter opening.
- R7: While `shutter` is low, both counters and the hit flag hold their values, whatever `disc` does.
- R8: The hit flag is set by the first rising discriminator edge in an open window and stays set until the next opening.
- R9: With `wrap_en`=1, a counter at all ones that is incremented goes to 0, and the matching carry output is high in that cycle. With `wrap_en`=0, the carry outputs stay low.
- R10: With `upper`=1, counter A advances only on `carry_a_in` and counter B advances only on `carry_b_in`. The pixel's own `disc` has no effect on either counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shutter | input | 1 | Global acquisition window, high while open |
| disc | input | 1 | Discriminator output, synchronous to clk |
| mode | input | 1 | 0: arrival time + width, 1: pulse count + width |
| upper | input | 1 | 1: higher segment of a linked group, follows carry inputs |
| wrap_en | input | 1 | 1: counters wrap and emit carries; 0: counters saturate |
| carry_a_in | input | 1 | Carry from the lower segment, counter A |
| carry_b_in | input | 1 | Carry from the lower segment, counter B |
| cnt_a | output | W | Counter A: arrival time or pulse count |
| cnt_b | output | W | Counter B: time over threshold |
| hit | output | 1 | Pixel saw a rising edge in this window |
| carry_a_out | output | 1 | Counter A wrapped this cycle |
| carry_b_out | output | 1 | Counter B wrapped this cycle |

## Verification
Every counter and the hit flag update at the same clock edge that samples the causing input. A value is therefore visible one edge after the cycle in which the event was driven. Carries pass combinationally into a linked upper segment, so that segment updates at the same edge as the low segment.

The driver changes inputs on falling edges. It closes the shutter and then wiggles `disc` for several cycles. Only then does it hand an expected record to the monitor. The monitor samples on the next falling edge, well after the last edge that could change the outputs. Any late or spurious count during the closed phase would therefore show up as a mismatch.

// File: rtl/pix_dual_counter.sv
module pix_dual_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shutter,
  input  logic         disc,
  input  logic         mode,
  input  logic         upper,
  input  logic         wrap_en,
  input  logic         carry_a_in,
  input  logic         carry_b_in,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         hit,
  output logic         carry_a_out,
  output logic         carry_b_out
);
  localparam logic [W-1:0] MAX = '1;

  logic sh_q, disc_q;
  logic open_edge, live, rise;
  logic inc_a, inc_b, full_a, full_b, step_a, step_b;

  assign open_edge = shutter & ~sh_q;
  assign live      = shutter & ~open_edge;
  assign rise      = disc & ~disc_q;

  assign inc_a = live & (upper ? carry_a_in : (mode ? rise : (hit | rise)));
  assign inc_b = live & (upper ? carry_b_in : disc);

  assign full_a = (cnt_a == MAX);
  assign full_b = (cnt_b == MAX);
  assign step_a = inc_a & (wrap_en | ~full_a);
  assign step_b = inc_b & (wrap_en | ~full_b);

  assign carry_a_out = inc_a & full_a & wrap_en;
  assign carry_b_out = inc_b & full_b & wrap_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= 1'b0;
      disc_q <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
      hit    <= 1'b0;
    end else begin
      sh_q   <= shutter;
      disc_q <= disc;
      if (open_edge) begin
        cnt_a <= '0;
        cnt_b <= '0;
        hit   <= 1'b0;
      end else begin
        if (step_a) cnt_a <= cnt_a + 1'b1;
        if (step_b) cnt_b <= cnt_b + 1'b1;
        if (live && rise) hit <= 1'b1;
      end
    end
  end

  assert_clear_on_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter) |=> (cnt_a == '0 && cnt_b == '0 && !hit));

  assert_hold_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(hit)));

  assert_saturate_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && cnt_a == MAX && !$rose(shutter)) |=> cnt_a == MAX);

  assert_saturate_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && cnt_b == MAX && !$rose(shutter)) |=> cnt_b == MAX);

  assert_hit_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !$rose(shutter)) |=> hit);

  assert_no_carry_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_en |-> (!carry_a_out && !carry_b_out));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shutter && !$rose(shutter)) |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1
                                      || (cnt_a == '0 && $past(cnt_a) == MAX)));
endmodule

// File: tb/pix_dual_counter_bench.sv
module pix_dual_counter_bench;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic shutter = 0, disc = 0, mode = 0, wrap_en = 0;
  logic [W-1:0] cnt_a, cnt_b, hi_a, hi_b;
  logic hit, hi_hit, ca, cb, hca, hcb;

  always #4 clk = ~clk;

  pix_dual_counter #(.W(W)) u_pix_dual_counter (
    .clk(clk), .rst_n(rst_n), .shutter(shutter), .disc(disc), .mode(mode),
    .upper(1'b0), .wrap_en(wrap_en), .carry_a_in(1'b0), .carry_b_in(1'b0),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .hit(hit), .carry_a_out(ca), .carry_b_out(cb));

  pix_dual_counter #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .shutter(shutter), .disc(1'b1), .mode(mode),
    .upper(1'b1), .wrap_en(1'b0), .carry_a_in(ca), .carry_b_in(cb),
    .cnt_a(hi_a), .cnt_b(hi_b), .hit(hi_hit), .carry_a_out(hca), .carry_b_out(hcb));

  int checks = 0, errors = 0;
  logic [16:0] expq[$];
  string tagq[$];
  event chk_ev;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({t, " cnt_a"}, cnt_a, e[16:13]);
        check("R4 cnt_b", cnt_b, e[12:9]);
        check("R8 hit", hit, e[8]);
        check("R9/R10 upper cnt_a", hi_a, e[7:4]);
        check("R9/R10 upper cnt_b", hi_b, e[3:0]);
      end
    end
  end

  function automatic logic [7:0] seg(int raw, bit wr);
    int t;
    if (wr) begin
      t = (raw > 255) ? 255 : raw;
      return {4'(t / 16), 4'(t % 16)};
    end
    return {4'd0, 4'((raw > 15) ? 15 : raw)};
  endfunction

  task automatic frame(string tag, bit md, bit wr, int n, logic [63:0] p);
    int first = 0, rises = 0, tot = 0, araw;
    bit prev = 0;
    logic [7:0] sa, sb;
    for (int i = 1; i <= n; i++) begin
      if (p[i] && !prev) begin rises++; if (first == 0) first = i; end
      tot += p[i];
      prev = p[i];
    end
    araw = md ? rises : (first != 0 ? n - first + 1 : 0);
    sa = seg(araw, wr);
    sb = seg(tot, wr);
    @(negedge clk); mode = md; wrap_en = wr; shutter = 1; disc = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); disc = p[i];
    end
    @(negedge clk); shutter = 0; disc = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); disc = i[0];
    end
    disc = 0;
    expq.push_back({sa[3:0], sb[3:0], rises > 0, sa[7:4], sb[7:4]});
    tagq.push_back(tag);
    -> chk_ev;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cnt_a", cnt_a, 0);
    check("R1 cnt_b", cnt_b, 0);
    check("R1 hit", hit, 0);
    rst_n = 1;
    @(negedge clk);
    frame("R3 single pulse toa", 0, 0, 12, 64'b0000_0011_1000);
    frame("R3 later edges ignored", 0, 0, 16, 64'b0110_0111_0011_0000);
    frame("R5 pulse count", 1, 0, 14, 64'b01_0011_0100_1100);
    frame("R2 empty frame clears", 0, 0, 10, 64'd0);
    frame("R6 saturate toa", 0, 0, 30, 64'h03FF_FFFE);
    frame("R6 saturate count", 1, 0, 40, 64'h0155_5555_5554 & 64'h01_FFFF_FFFE);
    frame("R9 wrap toa chain", 0, 1, 40, 64'h0000_001F_FFFE);
    frame("R9 wrap count chain", 1, 1, 44, 64'h0AAA_AAAA_AAAA);
    frame("R10 upper ignores disc", 0, 0, 8, 64'b0_0110);
    frame("R7 hold after close", 1, 0, 6, 64'b101_0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule